// File: doc/BRIEF.md
# Nibble Lookup Table Reader

This block fetches 4-bit table elements from a program store that is organised as 16-bit words. Software first builds a 16-bit element address by writing four 4-bit pointer registers, one write per register. It then issues a table-read command. The block places the word address on a one-cycle-latency memory port. When the word returns, it keeps the addressed nibble and presents it on a result stream, from which it can be moved into data RAM.

The read command and the result both use valid/ready handshakes. Back-pressure follows these rules:
- A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high.
- Only one read is in flight at a time, so `cmd_ready` stays low from acceptance until the result has been consumed.
- Once `res_valid` rises, it and `res_data` hold unchanged until the consumer asserts `res_ready`. The result is consumed on that edge.

Pointer writes are plain control inputs and are accepted in every cycle.

Top module: `nibble_table_reader`

## Requirements
- R1: After reset all four pointer registers are zero, `cmd_ready` is 1 and `res_valid` is 0. A read issued without any pointer write returns bits [3:0] of word 0.
- R2: A pointer write with `ptr_wr_sel`=k loads `ptr_wr_data` into address bits [4k+3:4k] and leaves the other three registers unchanged. Register 0 holds the least significant nibble.
- R3: An accepted command drives `mem_rd_en` high for exactly that one cycle. In that cycle `mem_addr` equals element address bits [15:2].
- R4: With element address bits [1:0]=n, `res_data` equals bits [4n+3:4n] of the returned word.
- R5: The memory returns data one cycle after the address. `res_valid` rises after the second rising edge following acceptance, and it is low in the cycle between.
- R6: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` stay stable and `cmd_ready` stays low. A high `res_ready` consumes the result on that edge.
- R7: A table read does not change the pointer. Two reads with no pointer write between them return the same word address and nibble.
- R8: A read uses the pointer value held at the edge where it is accepted. A pointer write in the accept cycle or in the fetch cycle does not change that read's result, and it takes effect for the next read.
- R9: While `cmd_ready` is low, `cmd_valid` starts no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_wr_en | input | 1 | Pointer register write strobe |
| ptr_wr_sel | input | 2 | Which pointer register to write (0 = least significant nibble) |
| ptr_wr_data | input | 4 | Nibble to write |
| cmd_valid | input | 1 | Table-read command valid |
| cmd_ready | output | 1 | Block can accept a command |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 14 | Word address to memory |
| mem_rdata | input | 16 | Word from memory, one cycle after `mem_rd_en` |
| res_valid | output | 1 | Result nibble valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 4 | Selected nibble |

## Verification
The bench builds the block with its default parameters: four 4-bit pointer registers over a 16-bit word, which gives a 14-bit word address. At these values, the table vectors reach both ends of the store, including element 0xFFFF in word 0x3FFF. They also cover all four nibble positions and each pointer register written on its own. The memory model derives every word from its address, so a wrong word address or a wrong lane shows up as a wrong nibble.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_HOLD  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/tblrd_ptr_bank.sv
module tblrd_ptr_bank #(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 4,
  localparam int SEL_W  = (NUM_NIB > 1) ? $clog2(NUM_NIB) : 1,
  localparam int PTR_W  = NIB_W * NUM_NIB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NIB_W-1:0] wr_data,
  output logic [PTR_W-1:0] ptr
);
  for (genvar k = 0; k < NUM_NIB; k++) begin : g_nib
    logic [NIB_W-1:0] nib_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              nib_q <= '0;
      else if (wr_en && wr_sel == SEL_W'(k))   nib_q <= wr_data;
    end
    assign ptr[k*NIB_W +: NIB_W] = nib_q;
  end

  AST_PTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr)); // R7
endmodule

// File: rtl/tblrd_nib_sel.sv
module tblrd_nib_sel #(
  parameter int NIB_W   = 4,
  parameter int WORD_W  = 16,
  localparam int LANES  = WORD_W / NIB_W,
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [WORD_W-1:0] word,
  input  logic [LSEL_W-1:0] sel,
  output logic [NIB_W-1:0]  nib
);
  logic [NIB_W-1:0] lane [LANES];
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane[j] = word[j*NIB_W +: NIB_W];
  end
  assign nib = lane[sel];
endmodule

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
  import tblrd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic res_ready,
  output logic cmd_ready,
  output logic accept,
  output logic capture,
  output logic res_valid
);
  rd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_HOLD;
      ST_HOLD:  if (res_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign capture   = (state_q == ST_FETCH);
  assign res_valid = (state_q == ST_HOLD);

  AST_FETCH_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> res_valid); // R5
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (capture && !cmd_ready)); // R6
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept); // R3
endmodule

// File: rtl/nibble_table_reader.sv
module nibble_table_reader #(
  parameter int NIB_W    = 4,
  parameter int NUM_PTR  = 4,
  parameter int WORD_W   = 16,
  localparam int PSEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
  localparam int EADDR_W = NIB_W * NUM_PTR,
  localparam int LANES   = WORD_W / NIB_W,
  localparam int LSEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WADDR_W = EADDR_W - LSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ptr_wr_en,
  input  logic [PSEL_W-1:0]  ptr_wr_sel,
  input  logic [NIB_W-1:0]   ptr_wr_data,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  output logic               mem_rd_en,
  output logic [WADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [NIB_W-1:0]   res_data
);
  logic [EADDR_W-1:0] elem_addr;
  logic               accept, capture;
  logic [LSEL_W-1:0]  lane_q;
  logic [NIB_W-1:0]   lane_nib;
  logic [NIB_W-1:0]   res_q;

  tblrd_ptr_bank #(.NIB_W(NIB_W), .NUM_NIB(NUM_PTR)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr_en), .wr_sel(ptr_wr_sel),
    .wr_data(ptr_wr_data), .ptr(elem_addr)
  );

  tblrd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .res_ready(res_ready),
    .cmd_ready(cmd_ready), .accept(accept), .capture(capture), .res_valid(res_valid)
  );

  tblrd_nib_sel #(.NIB_W(NIB_W), .WORD_W(WORD_W)) u_sel (
    .word(mem_rdata), .sel(lane_q), .nib(lane_nib)
  );

  assign mem_rd_en = accept;
  assign mem_addr  = elem_addr[EADDR_W-1:LSEL_W];

  // lane index is frozen at acceptance so later pointer writes cannot move it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lane_q <= '0;
    else if (accept) lane_q <= elem_addr[LSEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_q <= '0;
    else if (capture) res_q <= lane_nib;
  end

  assign res_data = res_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R6
  AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_rd_en); // R9
endmodule

// File: tb/sim_nibble_table_reader.sv
`timescale 1ns/1ps
module sim_nibble_table_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_wr_en = 1'b0;
  logic [1:0]  ptr_wr_sel = '0;
  logic [3:0]  ptr_wr_data = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        mem_rd_en;
  logic [13:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [3:0]  res_data;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  logic [13:0] seen_addr = '0;

  always #2 clk = ~clk;

  nibble_table_reader u0 (
    .clk(clk), .rst_n(rst_n), .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel),
    .ptr_wr_data(ptr_wr_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  function automatic logic [15:0] wfun(input logic [13:0] a);
    return {a[5:0], a[13:10] ^ 4'hA, a[9:4]} ^ 16'h3C5A;
  endfunction

  function automatic logic [3:0] expect_nib(input logic [15:0] p);
    logic [15:0] w;
    w = wfun(p[15:2]);
    return w[p[1:0]*4 +: 4];
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= wfun(mem_addr);
      seen_addr <= mem_addr;
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr_ptr(input logic [1:0] sel, input logic [3:0] d);
    ptr_wr_en = 1'b1; ptr_wr_sel = sel; ptr_wr_data = d;
    @(negedge clk);
    ptr_wr_en = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    for (int k = 0; k < 4; k++) wr_ptr(2'(k), p[k*4 +: 4]);
  endtask

  // starts at negedge; afterwards the acceptance edge has passed
  task automatic rd_start();
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_full(input logic [15:0] p, input string req);
    int c0;
    c0 = rd_cnt;
    rd_start();
    chk(seen_addr == p[15:2], req, seen_addr, p[15:2]);
    chk(rd_cnt == c0 + 1, "R3", rd_cnt - c0, 1);
    chk(!res_valid && !cmd_ready, "R5", res_valid, 0);
    @(negedge clk);
    chk(res_valid, "R5", res_valid, 1);
    chk(res_data == expect_nib(p), req, res_data, expect_nib(p));
    @(negedge clk);
    chk(!res_valid && cmd_ready, "R6", res_valid, 0);
  endtask

  localparam logic [15:0] VEC [8] = '{16'hFFFF, 16'h0003, 16'h1234, 16'hABCD,
                                      16'h8001, 16'h7FFE, 16'h5556, 16'hC3A2};

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !res_valid, "R1", {cmd_ready, res_valid}, 2'b10);
    rd_full(16'h0000, "R1");

    // table walk: nibble lanes and word addresses
    for (int i = 0; i < 8; i++) begin
      set_ptr(VEC[i]);
      rd_full(VEC[i], "R4");
    end

    // each pointer register alone
    for (int k = 0; k < 4; k++) begin
      set_ptr(16'h0000);
      wr_ptr(2'(k), 4'h9);
      rd_full(16'(4'h9) << (4 * k), "R2");
    end

    // no auto-increment
    set_ptr(16'h4E27);
    rd_full(16'h4E27, "R7");
    rd_full(16'h4E27, "R7");

    // back-pressure and busy command
    begin
      int c0;
      set_ptr(16'h2D61);
      res_ready = 1'b0;
      rd_start();
      @(negedge clk);
      c0 = rd_cnt;
      cmd_valid = 1'b1;
      repeat (5) @(negedge clk);
      chk(res_valid && !cmd_ready, "R6", res_valid, 1);
      chk(res_data == expect_nib(16'h2D61), "R6", res_data, expect_nib(16'h2D61));
      chk(rd_cnt == c0, "R9", rd_cnt - c0, 0);
      cmd_valid = 1'b0;
      res_ready = 1'b1;
      @(negedge clk);
      chk(!res_valid && cmd_ready, "R6", res_valid, 0);
    end

    // pointer write in the accept cycle
    set_ptr(16'h6B30);
    ptr_wr_en = 1'b1; ptr_wr_sel = 2'd0; ptr_wr_data = 4'h2;
    cmd_valid = 1'b1;
    @(negedge clk);
    ptr_wr_en = 1'b0; cmd_valid = 1'b0;
    chk(seen_addr == 14'(16'h6B30 >> 2), "R8", seen_addr, 16'h6B30 >> 2);
    @(negedge clk);
    chk(res_data == expect_nib(16'h6B30), "R8", res_data, expect_nib(16'h6B30));
    @(negedge clk);
    rd_full(16'h6B32, "R8");

    // pointer write during the fetch cycle
    set_ptr(16'h91C1);
    rd_start();
    wr_ptr(2'd0, 4'h3);
    chk(res_data == expect_nib(16'h91C1), "R8", res_data, expect_nib(16'h91C1));
    @(negedge clk);
    rd_full(16'h91C3, "R8");

    finish_run();
  end
endmodule